// File: doc/BRIEF.md
# Serial Flash Execute-in-Place Byte Reader

This block lets a processor fetch code one byte at a time straight out of an external serial flash. For each fetch the block opens a four-wire SPI transaction. It pulls chip select low and sends the fast-read command (0x0B), then a 24-bit address and one dummy byte. It then shifts in eight data bits and pulses a ready strobe towards the processor.

Once a byte has been delivered, the transaction stays open. If the next fetch address is the previous one plus one, the block only clocks in eight more bits. Any other address closes the transaction: chip select rises, stays high for a minimum gap, and a fresh command and address are sent. A transaction that sees no fetch for a set number of cycles is also closed.

The processor raises `req_i` with `addr_i` and holds both until it sees `rdy_o`. It drops `req_i` in the cycle after the pulse. The block accepts a request only when it is idle or holding an open transaction.

Top module: `spi_xip_reader`

## Requirements
- R1: After reset `spi_cs_no` is 1, `spi_sck_o` is 0, `rdy_o` is 0 and `data_o` is 0x00.
- R2: A request accepted while idle pulls `spi_cs_no` low, and the first eight bits on `spi_mosi_o` are 0x0B, most significant bit first.
- R3: The command is followed by the 24-bit fetch address, MSB first, then by eight serial clocks with `spi_mosi_o` at 0 before any data bit is sampled.
- R4: A data byte is taken from `spi_miso_i` MSB first on eight rising serial edges. `rdy_o` is then high for exactly one system cycle with the byte on `data_o`, and `data_o` changes only in a cycle where `rdy_o` is high.
- R5: A fetch whose address equals the previous fetch address plus one (modulo 2^24) keeps `spi_cs_no` low and costs exactly eight serial clocks, with no command or address.
- R6: A fetch with any other address raises `spi_cs_no`, keeps it high for at least 2*CS_GAP_SCK*HALF_DIV system cycles, and then re-sends the command and the new address.
- R7: An open transaction with no request for IDLE_TO consecutive cycles is closed by raising `spi_cs_no`, and it stays open before that.
- R8: SPI mode 0: `spi_mosi_o` changes only while `spi_sck_o` is low, and `spi_sck_o` is low whenever `spi_cs_no` is high.
- R9: `spi_sck_o` has a half period of HALF_DIV system cycles and its first rising edge comes HALF_DIV cycles after acceptance. `rdy_o` is high in the cycle after the edge that samples the last data bit.
- R10: With no valid last address (after reset or after a timeout close), a fetch always starts a new transaction, even if its address is sequential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Fetch request, held until `rdy_o` |
| addr_i | input | ADDR_W | Fetch byte address |
| rdy_o | output | 1 | One-cycle byte-ready pulse |
| data_o | output | 8 | Fetched byte, held until the next pulse |
| spi_cs_no | output | 1 | Flash chip select, active low |
| spi_sck_o | output | 1 | Serial clock, idle low |
| spi_mosi_o | output | 1 | Serial data to flash |
| spi_miso_i | input | 1 | Serial data from flash |

## Verification
Timing follows from HALF_DIV (H), measured in system cycles from the cycle in which the request is raised. A fetch from idle shows `rdy_o` after 95*H+1 cycles. A sequential fetch shows it after 15*H+1 cycles. A fetch that breaks the sequence shows it after 99*H+2 cycles, because the chip-select gap comes first. The bench counts the falling system edges until it sees `rdy_o` and compares that count with these figures. It also waits 2*H cycles after each pulse before raising the next request, so the trailing serial edge has finished and the latency never depends on that edge. A flash model decodes the command, address and dummy bits on the serial lines. The flash model also returns a byte computed from the address. A scoreboard compares each `rdy_o` byte with the value the driver queued.

// File: rtl/spi_xip_pkg.sv
package spi_xip_pkg;
  localparam logic [7:0] FAST_READ_OP = 8'h0B;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_FINISH,
    ST_HOLD,
    ST_GAP
  } xip_state_e;
endpackage

// File: rtl/spi_xip_sck_gen.sv
module spi_xip_sck_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] TERM = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          sck_q;
  logic          term;

  assign term   = en_i && (cnt_q == TERM);
  assign rise_o = term && !sck_q;
  assign fall_o = term && sck_q;
  assign sck_o  = sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R9: every toggle is preceded by a full half period of the enable
  a_r9_no_early_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && sck_o != $past(sck_o)) |-> $past(cnt_q) == TERM);
endmodule

// File: rtl/spi_xip_seq_track.sv
module spi_xip_seq_track #(
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              clear_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0] last_q;
  logic              valid_q;

  assign hit_o = valid_q && (addr_i == last_q + 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q  <= '0;
      valid_q <= 1'b0;
    end else if (clear_i) begin
      valid_q <= 1'b0;
    end else if (load_i) begin
      last_q  <= addr_i;
      valid_q <= 1'b1;
    end
  end

  // R10: a close leaves nothing to continue from
  a_r10_clear_kills_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !hit_o);
endmodule

// File: rtl/spi_xip_reader.sv
module spi_xip_reader
  import spi_xip_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int HALF_DIV   = 4,
  parameter int CS_GAP_SCK = 2,
  parameter int IDLE_TO    = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rdy_o,
  output logic [7:0]        data_o,
  output logic              spi_cs_no,
  output logic              spi_sck_o,
  output logic              spi_mosi_o,
  input  logic              spi_miso_i
);
  localparam int TX_W      = 8 + ADDR_W;
  localparam int HDR_BITS  = TX_W + 8;
  localparam int DONE_BITS = HDR_BITS + 8;
  localparam int BC_W      = $clog2(DONE_BITS + 1);
  localparam int GAP_CYC   = 2 * CS_GAP_SCK * HALF_DIV;
  localparam int GAP_W     = $clog2(GAP_CYC + 1);
  localparam int TO_W      = $clog2(IDLE_TO + 1);

  xip_state_e       state_q;
  logic [TX_W-1:0]  tx_q;
  logic [7:0]       rx_q;
  logic [BC_W-1:0]  bit_q;
  logic [GAP_W-1:0] gap_q;
  logic [TO_W-1:0]  to_q;
  logic             cs_q, rdy_q;
  logic [7:0]       data_q;

  logic sck_en, sck_rise, sck_fall;
  logic seq_hit, seq_load, close_w;

  assign sck_en   = (state_q == ST_SHIFT) || (state_q == ST_FINISH);
  assign close_w  = (state_q == ST_HOLD) &&
                    ((req_i && !seq_hit) || (!req_i && to_q == TO_W'(IDLE_TO - 1)));
  assign seq_load = req_i && ((state_q == ST_IDLE) || (state_q == ST_HOLD && seq_hit));

  spi_xip_sck_gen #(.HALF_DIV(HALF_DIV)) u_sck (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (sck_en),
    .sck_o  (spi_sck_o),
    .rise_o (sck_rise),
    .fall_o (sck_fall)
  );

  spi_xip_seq_track #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (seq_load),
    .clear_i (close_w),
    .addr_i  (addr_i),
    .hit_o   (seq_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tx_q    <= '0;
      rx_q    <= '0;
      bit_q   <= '0;
      gap_q   <= '0;
      to_q    <= '0;
      cs_q    <= 1'b1;
      rdy_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      rdy_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          cs_q    <= 1'b0;
          tx_q    <= {FAST_READ_OP, addr_i};
          bit_q   <= '0;
          state_q <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (sck_rise) begin
            bit_q <= bit_q + 1'b1;
            if (bit_q >= BC_W'(HDR_BITS)) rx_q <= {rx_q[6:0], spi_miso_i};
            if (bit_q == BC_W'(DONE_BITS - 1)) begin
              data_q  <= {rx_q[6:0], spi_miso_i};
              rdy_q   <= 1'b1;
              state_q <= ST_FINISH;
            end
          end
          if (sck_fall) tx_q <= tx_q << 1;
        end
        ST_FINISH: if (sck_fall) begin
          to_q    <= '0;
          state_q <= ST_HOLD;
        end
        ST_HOLD: begin
          if (close_w) begin
            cs_q    <= 1'b1;
            gap_q   <= '0;
            state_q <= ST_GAP;
          end else if (req_i) begin
            bit_q   <= BC_W'(HDR_BITS);
            state_q <= ST_SHIFT;
          end else begin
            to_q <= to_q + 1'b1;
          end
        end
        ST_GAP: begin
          if (gap_q == GAP_W'(GAP_CYC - 1)) state_q <= ST_IDLE;
          else gap_q <= gap_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign spi_cs_no  = cs_q;
  assign spi_mosi_o = tx_q[TX_W-1];
  assign rdy_o      = rdy_q;
  assign data_o     = data_q;

  // checker state: length of the current deselect interval
  logic [GAP_W-1:0] hi_cnt_q;
  logic             ever_low_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt_q   <= '0;
      ever_low_q <= 1'b0;
    end else if (spi_cs_no) begin
      if (hi_cnt_q != GAP_W'(GAP_CYC)) hi_cnt_q <= hi_cnt_q + 1'b1;
    end else begin
      hi_cnt_q   <= '0;
      ever_low_q <= 1'b1;
    end
  end

  a_r8_sck_low_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sck_o);
  a_r8_mosi_stable_sck_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_sck_o |-> $stable(spi_mosi_o));
  a_r4_rdy_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |=> !rdy_o);
  a_r4_data_only_with_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> rdy_o);
  a_r6_cs_min_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(spi_cs_no) && ever_low_q) |-> hi_cnt_q >= GAP_W'(GAP_CYC));
endmodule

// File: tb/tb_spi_xip_reader.sv
`timescale 1ns/1ps
module tb_spi_xip_reader;
  localparam int H      = 2;
  localparam int TO     = 40;
  localparam int GAPSCK = 2;
  localparam int LAT_NEW = 95 * H + 1;
  localparam int LAT_SEQ = 15 * H + 1;
  localparam int LAT_BRK = 99 * H + 2;

  logic clk_i = 1'b0, rst_ni = 1'b0, req_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic rdy_o, spi_cs_no, spi_sck_o, spi_mosi_o;
  logic spi_miso_i = 1'b0;
  logic [7:0] data_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  spi_xip_reader #(.ADDR_W(24), .HALF_DIV(H), .CS_GAP_SCK(GAPSCK), .IDLE_TO(TO)) dut (
    .clk_i, .rst_ni, .req_i, .addr_i, .rdy_o, .data_o,
    .spi_cs_no, .spi_sck_o, .spi_mosi_o, .spi_miso_i
  );

  function automatic logic [7:0] fdat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // flash model
  int txn_cnt = 0, rise_idx = 0, dummy_ones = 0;
  logic [7:0]  cmd_sh = '0, last_cmd = '0;
  logic [23:0] addr_sh = '0, last_addr = '0;

  always @(negedge spi_cs_no) begin
    txn_cnt++;
    rise_idx = 0;
    dummy_ones = 0;
  end

  always @(posedge spi_sck_o) begin
    if (rise_idx < 8) cmd_sh = {cmd_sh[6:0], spi_mosi_o};
    else if (rise_idx < 32) addr_sh = {addr_sh[22:0], spi_mosi_o};
    else if (rise_idx < 40) dummy_ones += int'(spi_mosi_o);
    rise_idx++;
    if (rise_idx == 8) last_cmd = cmd_sh;
    if (rise_idx == 32) last_addr = addr_sh;
  end

  always @(negedge spi_sck_o) begin
    if (rise_idx >= 40) begin
      automatic int d = rise_idx - 40;
      automatic logic [7:0] b = fdat(last_addr + 24'(d / 8));
      spi_miso_i = b[7 - (d % 8)];
    end
  end

  // line monitors
  int mode_bad = 0, hi_run = 0, last_hi_run = 0;
  logic prev_sck = 1'b0, prev_mosi = 1'b0, prev_cs = 1'b1;
  always @(negedge clk_i) if (rst_ni) begin
    if (spi_sck_o && prev_sck && spi_mosi_o != prev_mosi) mode_bad++;
    if (spi_cs_no && spi_sck_o) mode_bad++;
    if (spi_cs_no) hi_run++;
    else if (prev_cs) begin
      last_hi_run = hi_run;
      hi_run = 0;
    end
    prev_sck = spi_sck_o; prev_mosi = spi_mosi_o; prev_cs = spi_cs_no;
  end

  // scoreboard
  logic [7:0] exp_q[$];
  always @(negedge clk_i) if (rst_ni && rdy_o) begin
    if (exp_q.size() == 0) chk(1'b0, "R4", "unexpected rdy", data_o, 0);
    else begin
      automatic logic [7:0] e = exp_q.pop_front();
      chk(data_o == e, "R4", "byte", data_o, e);
    end
  end

  task automatic fetch(input logic [23:0] a, input int exp_lat, input bit exp_new, input string tag);
    int t0, r0, n;
    t0 = txn_cnt;
    r0 = rise_idx;
    exp_q.push_back(fdat(a));
    addr_i = a;
    req_i = 1'b1;
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!rdy_o && n < 1000);
    req_i = 1'b0;
    chk(n == exp_lat, tag, "rdy latency", n, exp_lat);
    if (exp_new) begin
      chk(txn_cnt == t0 + 1, tag, "new transaction", txn_cnt, t0 + 1);
      chk(last_cmd == 8'h0B, "R2", "opcode", last_cmd, 8'h0B);
      chk(last_addr == a, "R3", "address", last_addr, a);
      chk(dummy_ones == 0, "R3", "dummy bits", dummy_ones, 0);
      chk(rise_idx == 48, "R3", "serial clocks", rise_idx, 48);
    end else begin
      chk(txn_cnt == t0, "R5", "cs held", txn_cnt, t0);
      chk(rise_idx == r0 + 8, "R5", "eight clocks", rise_idx, r0 + 8);
    end
    repeat (2 * H) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(spi_cs_no == 1'b1, "R1", "cs reset", spi_cs_no, 1);
    chk(spi_sck_o == 1'b0, "R1", "sck reset", spi_sck_o, 0);
    chk(rdy_o == 1'b0, "R1", "rdy reset", rdy_o, 0);
    chk(data_o == 8'h00, "R1", "data reset", data_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    fetch(24'h001000, LAT_NEW, 1'b1, "R10");   // R9 latency from idle
    fetch(24'h001001, LAT_SEQ, 1'b0, "R5");
    fetch(24'h001002, LAT_SEQ, 1'b0, "R9");
    repeat (5) @(negedge clk_i);
    chk(data_o == fdat(24'h001002), "R4", "data held", data_o, fdat(24'h001002));
    fetch(24'h00ABCD, LAT_BRK, 1'b1, "R6");
    chk(last_hi_run >= 4 * H, "R6", "cs gap", last_hi_run, 4 * H);
    fetch(24'h00ABCD, LAT_BRK, 1'b1, "R6");
    chk(last_hi_run >= 4 * H, "R6", "cs gap repeat", last_hi_run, 4 * H);
    fetch(24'h00ABCE, LAT_SEQ, 1'b0, "R5");
    repeat (10) @(negedge clk_i);
    chk(spi_cs_no == 1'b0, "R7", "open before timeout", spi_cs_no, 0);
    repeat (40) @(negedge clk_i);
    chk(spi_cs_no == 1'b1, "R7", "closed after timeout", spi_cs_no, 1);
    fetch(24'h00ABCF, LAT_NEW, 1'b1, "R10");
    fetch(24'hFFFFFF, LAT_BRK, 1'b1, "R6");
    fetch(24'h000000, LAT_SEQ, 1'b0, "R5");
    repeat (4) @(negedge clk_i);
    chk(mode_bad == 0, "R8", "mode 0 violations", mode_bad, 0);
    chk(exp_q.size() == 0, "R4", "bytes outstanding", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "R9", "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule